// File: doc/BRIEF.md
# Key-Gated System Configuration Registers

This block is a small system-controller register file. It holds a device configuration word and a clock divider word, whose bits drive pin-multiplexing and clock logic elsewhere on the chip. It also exposes a read-only information word that carries the chip revision. Software reaches it over a plain single-cycle register bus. A write lands in the cycle where `bus_sel` and `bus_wr` are both high. A read returns `bus_rdata` combinationally for the address presented.

The configuration and divider words are protected. A write to either one is accepted only when the immediately preceding bus write put the key value into the lock register. Any bus write, whatever it targets, uses up the armed state. Software therefore sets the key and then performs its read-modify-write of the target, with nothing in between.

One bit of the configuration word is a software reset request. Software first sets it, in one protected write, and then clears it, in a second protected write. When the bit falls, the block emits a reset pulse of fixed length.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, `devcfg_o`, `clkdiv_o` and `sw_reset_o` are 0, and a read of address 0 (lock) returns 0.
- R2: A write of exactly 32'h0000_00AA to address 0 arms the block. While armed, a read of address 0 returns 1; otherwise it returns 0.
- R3: A write to address 0 of any value other than 32'h0000_00AA leaves the block unarmed. This includes values whose low byte is 0xAA.
- R4: A write to address 1 (configuration) or address 2 (divider) while unarmed leaves that register unchanged.
- R5: Every bus write disarms the block after it completes, whether it targets a protected register, the information word or the lock. Reads leave the armed state as it is.
- R6: A write to address 1 or 2 while armed stores the full 32-bit value. It appears on `devcfg_o` or `clkdiv_o` and in the read data of that address after the write's clock edge.
- R7: Address 3 reads the revision value in bits [11:8] and zero elsewhere. Writes to it change nothing.
- R8: A 1-to-0 change of configuration bit 31 makes `sw_reset_o` high for exactly 4 consecutive cycles. The pulse begins at the second clock edge after the clearing write is accepted.
- R9: Setting bit 31, or rewriting it with an unchanged value, produces no reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 lock, 1 config, 2 divider, 3 info |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| devcfg_o | output | 32 | Device configuration word |
| clkdiv_o | output | 32 | Clock divider word |
| sw_reset_o | output | 1 | Software reset pulse |

## Verification
The hardest case to reach from the ports is a reset pulse. It needs two accepted protected writes in sequence, each preceded by its own key write, with the falling edge of bit 31 between them. The bench builds this from key/write pairs and then counts the high cycles of the pulse edge by edge.

A key sweep covers every 8-bit value in the lock register. Each key write is followed by a read of the lock, which must not disarm, and then by an attempted configuration write. Only 0xAA may change the configuration.

Further sequences put an unrelated write or a write to the information word between the key and the target, to show that the arm is used up.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {
    A_LOCK = 2'd0,
    A_DEV  = 2'd1,
    A_CLK  = 2'd2,
    A_INFO = 2'd3
  } sysctl_addr_e;
  localparam int unsigned KEY_VALUE = 32'h0000_00AA;
endpackage

// File: rtl/sysctl_keygate.sv
module sysctl_keygate #(
  parameter int DW  = 32,
  parameter int KEY = 32'h0000_00AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          is_lock,
  input  logic [DW-1:0] wdata,
  output logic          armed_o
);
  logic key_hit;
  assign key_hit = wr_en && is_lock && (wdata == DW'(KEY));

  always_ff @(posedge clk) begin
    if (!rst_n)     armed_o <= 1'b0;
    else if (wr_en) armed_o <= key_hit;
  end

  // R2
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> $past(wr_en && is_lock && wdata == DW'(KEY)));
  // R5
  arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_lock) |=> !armed_o);
  // R5
  read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(armed_o));
endmodule

// File: rtl/sysctl_rstpulse.sv
module sysctl_rstpulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_bit,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          fall;

  assign fall = prev_q && !req_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= req_bit;
      if (fall)             cnt_q <= CW'(LEN);
      else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse_o = (cnt_q != 0);

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(prev_q && !req_bit));
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_o && !fall) |=> !pulse_o);
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int DW        = 32,
  parameter int REV_LSB   = 8,
  parameter int REV_W     = 4,
  parameter int REV_VALUE = 5,
  parameter int SWRST_BIT = 31,
  parameter int RST_LEN   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] devcfg_o,
  output logic [DW-1:0] clkdiv_o,
  output logic          sw_reset_o
);
  localparam logic [DW-1:0] INFO_WORD = DW'(REV_VALUE) << REV_LSB;

  sysctl_addr_e a;
  logic wr_en, armed;
  logic [DW-1:0] devcfg_q, clkdiv_q;

  assign a     = sysctl_addr_e'(bus_addr);
  assign wr_en = bus_sel && bus_wr;

  sysctl_keygate #(.DW(DW), .KEY(KEY_VALUE)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .is_lock(a == A_LOCK),
    .wdata(bus_wdata), .armed_o(armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      devcfg_q <= '0;
      clkdiv_q <= '0;
    end else if (wr_en && armed) begin
      if (a == A_DEV) devcfg_q <= bus_wdata;
      if (a == A_CLK) clkdiv_q <= bus_wdata;
    end
  end

  always_comb begin
    case (a)
      A_LOCK:  bus_rdata = DW'(armed);
      A_DEV:   bus_rdata = devcfg_q;
      A_CLK:   bus_rdata = clkdiv_q;
      default: bus_rdata = INFO_WORD;
    endcase
  end

  sysctl_rstpulse #(.LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .req_bit(devcfg_q[SWRST_BIT]), .pulse_o(sw_reset_o)
  );

  assign devcfg_o = devcfg_q;
  assign clkdiv_o = clkdiv_q;

  // R4
  dev_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(devcfg_q) |-> $past(armed && wr_en && a == A_DEV));
  // R4
  clk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clkdiv_q) |-> $past(armed && wr_en && a == A_CLK));
  // R6
  dev_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && a == A_DEV) |=> devcfg_q == $past(bus_wdata));
endmodule

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, devcfg, clkdiv;
  logic swrst;
  int tests = 0, fails = 0;
  logic [31:0] exp_dev = 0, exp_clk = 0, rd;

  always #10 clk = ~clk;

  sysctl_regs u0 (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .devcfg_o(devcfg), .clkdiv_o(clkdiv), .sw_reset_o(swrst));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a; #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  initial begin
    #4000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 devcfg", devcfg, 0);
    check("R1 clkdiv", clkdiv, 0);
    check("R1 swrst", {31'b0, swrst}, 0);
    bread(0, rd); check("R1 lock", rd, 0);

    // R2 R3 R4 R6: key sweep; read of lock between key and target must not disarm (R5)
    for (int v = 0; v < 256; v++) begin
      logic [31:0] nv;
      nv = (v << 16) | (v ^ 32'h55);
      bwrite(0, v);
      bread(0, rd);
      check(v == 32'hAA ? "R2 lock armed" : "R3 lock stays", rd, (v == 32'hAA) ? 1 : 0);
      bwrite(1, nv);
      if (v == 32'hAA) exp_dev = nv;
      check(v == 32'hAA ? "R6 devcfg store" : "R4 devcfg ignore", devcfg, exp_dev);
    end
    // R3 upper bits set
    bwrite(0, 32'h0000_01AA); bwrite(2, 32'h1234); check("R3 wide key", clkdiv, 0);
    // R6 clkdiv store and readback
    bwrite(0, 32'hAA); bwrite(2, 32'hCAFE_0042); exp_clk = 32'hCAFE_0042;
    check("R6 clkdiv", clkdiv, exp_clk);
    bread(2, rd); check("R6 clkdiv read", rd, exp_clk);
    // R5 intervening write to unprotected info consumes arm
    bwrite(0, 32'hAA); bwrite(3, 32'hFFFF_FFFF); bwrite(2, 32'h1);
    check("R5 info consumes", clkdiv, exp_clk);
    // R5 intervening protected write consumes arm
    bwrite(0, 32'hAA); bwrite(1, exp_dev ^ 32'h0F); exp_dev ^= 32'h0F; bwrite(2, 32'h2);
    check("R5 second write", clkdiv, exp_clk);
    check("R5 first write", devcfg, exp_dev);
    bread(0, rd); check("R5 lock after write", rd, 0);
    // R7 info word
    bread(3, rd); check("R7 info", rd, 32'h0000_0500);
    // R6 read-modify-write
    bread(1, rd); bwrite(0, 32'hAA); bwrite(1, (rd & ~32'h00FF) | 32'h3000);
    exp_dev = (exp_dev & ~32'h00FF) | 32'h3000;
    check("R6 rmw", devcfg, exp_dev);
    // R9 setting bit 31 and rewriting it give no pulse
    bwrite(0, 32'hAA); bwrite(1, exp_dev | 32'h8000_0000);
    exp_dev = exp_dev | 32'h8000_0000;
    bwrite(0, 32'hAA); bwrite(1, exp_dev);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); check("R9 no pulse", {31'b0, swrst}, 0);
    end
    // R8 clearing bit 31 gives a 4-cycle pulse
    bwrite(0, 32'hAA); bwrite(1, exp_dev & 32'h7FFF_FFFF);
    exp_dev = exp_dev & 32'h7FFF_FFFF;
    check("R8 before pulse", {31'b0, swrst}, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); check("R8 pulse high", {31'b0, swrst}, 1);
    end
    @(negedge clk); check("R8 pulse end", {31'b0, swrst}, 0);
    check("R8 bit clear", devcfg, exp_dev);
    // R9 writing 0 when already 0
    bwrite(0, 32'hAA); bwrite(1, exp_dev);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); check("R9 zero rewrite", {31'b0, swrst}, 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule